// File: doc/BRIEF.md
# Memory-Mapped Register Bank with AXI4-Lite Slave Port

This block is a slave on a 32-bit AXI4-Lite bus that holds a small bank of read/write control registers. The five channels (write address, write data, write response, read address, read data) each use their own valid/ready handshake. The write address and write data may arrive in either order or together. The slave holds whichever arrives first and commits the write only when it has both. Each write updates only the byte lanes selected by its strobe. Each read returns the register selected by the address.

Each response channel holds its response until the master accepts it. While a response is waiting, the slave takes no new request on that side, so each side has at most one transaction in flight. A parameter enables a protection check: any access whose protection field marks it as an instruction fetch gets an error response and leaves the bank unchanged.

Top module: `axil_regbank`

## Requirements
- R1: While the synchronous active-low reset is asserted, every ready and every valid output is 0. All registers read back as zero after reset. The ready outputs become 1 in the first cycle after reset is released.
- R2: The write address and write data may be accepted in the same cycle or in either order with any gap between them. The write response does not become valid until both have been accepted. It becomes valid in the cycle right after the later of the two handshakes.
- R3: A write updates each byte lane of the target register whose strobe bit is 1. Strobe bit n controls data bits 8n+7..8n. Every lane whose strobe bit is 0 keeps its old value.
- R4: A write with strobe 4'b0000 leaves every register unchanged and still completes with an OKAY write response.
- R5: Once the write response is valid, it stays valid with an unchanged response code until the master accepts it with its ready. During that time, both the write address ready and the write data ready are 0.
- R6: Once the read response is valid, the read data and read response code stay unchanged until the master accepts them with its ready. During that time, the read address ready is 0.
- R7: The register is selected by address bits [3:2], giving four 32-bit registers. Address bits [1:0] and all bits above bit 3 have no effect.
- R8: A normal read or write answers with OKAY (2'b00). A read returns the current contents of the addressed register.
- R9: When the fetch-reject parameter is set, an access whose protection bit 2 is 1 is rejected. A rejected write answers SLVERR (2'b10) and changes no register. A rejected read answers SLVERR with all-zero data. Protection bits 1:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 8 | Write address |
| s_awprot | input | 3 | Write protection attributes |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address |
| s_arprot | input | 3 | Read protection attributes |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |

## Verification
A wrong pairing flag in the write path shows up at the ports within one cycle of a one-sided handshake. The symptoms are a write response with only one half of the write accepted, or a ready that stays high and lets a second address replace the first. A register that merges its lanes wrongly keeps that error until the next write, so it only shows when the register is read back. For this reason every write is followed by a read, using partial, empty and rejected strobe patterns. The response holding registers are checked by keeping the master's ready low for several cycles and checking that valid, data, code and the opposite ready do not move.

// File: rtl/axil_regbank_pkg.sv
package axil_regbank_pkg;

    typedef logic [1:0] resp_t;

    localparam resp_t RESP_OKAY   = 2'b00;
    localparam resp_t RESP_SLVERR = 2'b10;

    // Bit of the protection field that marks an instruction fetch
    localparam int PROT_FETCH_BIT = 2;

endpackage

// File: rtl/axil_wr_path.sv
module axil_wr_path
    import axil_regbank_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int NUM_REGS     = 4,
    parameter bit REJECT_FETCH = 1'b1,
    localparam int STRB_W      = DATA_W / 8,
    localparam int IDX_W       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr_i,
    input  logic [2:0]        awprot_i,
    input  logic              awvalid_i,
    output logic              awready_o,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STRB_W-1:0] wstrb_i,
    input  logic              wvalid_i,
    output logic              wready_o,
    output resp_t             bresp_o,
    output logic              bvalid_o,
    input  logic              bready_i,
    output logic              we_o,
    output logic [IDX_W-1:0]  widx_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [STRB_W-1:0] wstrb_o
);

    typedef struct packed {
        logic              run;
        logic              aw_full;
        logic [IDX_W-1:0]  idx;
        logic              fetch;
        logic              w_full;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              bvalid;
        resp_t             bresp;
    } wr_state_t;

    wr_state_t st_d, st_q;

    logic              aw_hs, w_hs, have_aw, have_w, commit, reject;
    logic [IDX_W-1:0]  idx_now;
    logic              fetch_now;
    logic [DATA_W-1:0] data_now;
    logic [STRB_W-1:0] strb_now;

    always_comb begin
        st_d      = st_q;
        st_d.run  = 1'b1;

        awready_o = st_q.run & ~st_q.aw_full & ~st_q.bvalid;
        wready_o  = st_q.run & ~st_q.w_full  & ~st_q.bvalid;
        aw_hs     = awvalid_i & awready_o;
        w_hs      = wvalid_i  & wready_o;

        have_aw   = st_q.aw_full | aw_hs;
        have_w    = st_q.w_full  | w_hs;
        idx_now   = st_q.aw_full ? st_q.idx   : awaddr_i[IDX_W+1:2];
        fetch_now = st_q.aw_full ? st_q.fetch : awprot_i[PROT_FETCH_BIT];
        data_now  = st_q.w_full  ? st_q.data  : wdata_i;
        strb_now  = st_q.w_full  ? st_q.strb  : wstrb_i;

        commit    = have_aw & have_w;
        reject    = REJECT_FETCH & fetch_now;

        if (bvalid_o && bready_i) begin
            st_d.bvalid = 1'b0;
        end

        if (commit) begin
            st_d.aw_full = 1'b0;
            st_d.w_full  = 1'b0;
            st_d.bvalid  = 1'b1;
            st_d.bresp   = reject ? RESP_SLVERR : RESP_OKAY;
        end else begin
            if (aw_hs) begin
                st_d.aw_full = 1'b1;
                st_d.idx     = idx_now;
                st_d.fetch   = fetch_now;
            end
            if (w_hs) begin
                st_d.w_full = 1'b1;
                st_d.data   = data_now;
                st_d.strb   = strb_now;
            end
        end

        we_o    = commit & ~reject;
        widx_o  = idx_now;
        wdata_o = data_now;
        wstrb_o = strb_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bvalid_o = st_q.bvalid;
    assign bresp_o  = st_q.bresp;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{awaddr_i, awprot_i};

    // R5: a pending write response waits for the master, code unchanged
    a_r5_bvalid_held: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid_o && !bready_i |=> bvalid_o && $stable(bresp_o));

    // R5: nothing new is accepted while a write response is pending
    a_r5_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid_o |-> !awready_o && !wready_o);

    // R2: an address alone never produces a response
    a_r2_wait_for_data: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid_i && awready_o && !(wvalid_i && wready_o) && !st_q.w_full |=> !bvalid_o);

    // R2: data alone never produces a response
    a_r2_wait_for_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid_i && wready_o && !(awvalid_i && awready_o) && !st_q.aw_full |=> !bvalid_o);

endmodule

// File: rtl/axil_rd_path.sv
module axil_rd_path
    import axil_regbank_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int NUM_REGS     = 4,
    parameter bit REJECT_FETCH = 1'b1,
    localparam int IDX_W       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr_i,
    input  logic [2:0]        arprot_i,
    input  logic              arvalid_i,
    output logic              arready_o,
    output logic [DATA_W-1:0] rdata_o,
    output resp_t             rresp_o,
    output logic              rvalid_o,
    input  logic              rready_i,
    output logic [IDX_W-1:0]  ridx_o,
    input  logic [DATA_W-1:0] reg_data_i
);

    typedef struct packed {
        logic              run;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        resp_t             rresp;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      ar_hs, reject;

    always_comb begin
        st_d      = st_q;
        st_d.run  = 1'b1;
        arready_o = st_q.run & ~st_q.rvalid;
        ar_hs     = arvalid_i & arready_o;
        ridx_o    = araddr_i[IDX_W+1:2];
        reject    = REJECT_FETCH & arprot_i[PROT_FETCH_BIT];

        if (st_q.rvalid && rready_i) begin
            st_d.rvalid = 1'b0;
        end
        if (ar_hs) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = reject ? '0 : reg_data_i;
            st_d.rresp  = reject ? RESP_SLVERR : RESP_OKAY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rvalid_o = st_q.rvalid;
    assign rdata_o  = st_q.rdata;
    assign rresp_o  = st_q.rresp;

    logic unused_rd_bits;
    assign unused_rd_bits = ^{araddr_i, arprot_i};

    // R6: the read response is held until accepted
    a_r6_rvalid_held: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o) && $stable(rresp_o));

    // R6: no read address accepted while a read response is pending
    a_r6_arready_low: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> !arready_o);

    // R9: a fetch-marked read answers SLVERR with zero data
    a_r9_fetch_read: assert property (@(posedge clk) disable iff (!rst_n)
        REJECT_FETCH && arvalid_i && arready_o && arprot_i[PROT_FETCH_BIT]
        |=> rvalid_o && rresp_o == RESP_SLVERR && rdata_o == '0);

endmodule

// File: rtl/axil_reg_file.sv
module axil_reg_file #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    localparam int STRB_W  = DATA_W / 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STRB_W-1:0] wstrb_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            for (int lane = 0; lane < STRB_W; lane++) begin
                if (wstrb_i[lane]) begin
                    regs_d[widx_i][lane*8 +: 8] = wdata_i[lane*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rdata_o = regs_q[ridx_i];

    // R4: an empty strobe leaves the whole bank untouched
    a_r4_zero_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        we_i && wstrb_i == '0 |=> regs_q == $past(regs_q));

    for (genvar j = 0; j < STRB_W; j++) begin : g_lane_chk
        // R3: a selected lane takes the new byte
        a_r3_lane_written: assert property (@(posedge clk) disable iff (!rst_n)
            we_i && wstrb_i[j]
            |=> regs_q[$past(widx_i)][j*8 +: 8] == $past(wdata_i[j*8 +: 8]));
        // R3: an unselected lane keeps its byte
        a_r3_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
            we_i && !wstrb_i[j]
            |=> regs_q[$past(widx_i)][j*8 +: 8] == $past(regs_q[widx_i][j*8 +: 8]));
    end

endmodule

// File: rtl/axil_regbank.sv
module axil_regbank
    import axil_regbank_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int NUM_REGS     = 4,
    parameter bit REJECT_FETCH = 1'b1,
    localparam int STRB_W      = DATA_W / 8,
    localparam int IDX_W       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [2:0]        s_awprot,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic [2:0]        s_arprot,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);

    logic              we;
    logic [IDX_W-1:0]  widx, ridx;
    logic [DATA_W-1:0] wdata, reg_rdata;
    logic [STRB_W-1:0] wstrb;

    axil_wr_path #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .REJECT_FETCH(REJECT_FETCH)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr_i(s_awaddr), .awprot_i(s_awprot), .awvalid_i(s_awvalid), .awready_o(s_awready),
        .wdata_i(s_wdata), .wstrb_i(s_wstrb), .wvalid_i(s_wvalid), .wready_o(s_wready),
        .bresp_o(s_bresp), .bvalid_o(s_bvalid), .bready_i(s_bready),
        .we_o(we), .widx_o(widx), .wdata_o(wdata), .wstrb_o(wstrb)
    );

    axil_rd_path #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .REJECT_FETCH(REJECT_FETCH)
    ) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr_i(s_araddr), .arprot_i(s_arprot), .arvalid_i(s_arvalid), .arready_o(s_arready),
        .rdata_o(s_rdata), .rresp_o(s_rresp), .rvalid_o(s_rvalid), .rready_i(s_rready),
        .ridx_o(ridx), .reg_data_i(reg_rdata)
    );

    axil_reg_file #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_i(we), .widx_i(widx), .wdata_i(wdata), .wstrb_i(wstrb),
        .ridx_i(ridx), .rdata_o(reg_rdata)
    );

    // R9: a rejected write never reaches the register bank
    a_r9_fetch_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && s_bresp == RESP_SLVERR |-> !we);

endmodule

// File: tb/axil_regbank_tb.sv
`timescale 1ns/1ps
module axil_regbank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  awaddr = '0, araddr = '0;
    logic [2:0]  awprot = '0, arprot = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] model [4];

    always #10 clk = ~clk;

    axil_regbank u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awprot(awprot), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arprot(arprot), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] s);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (s[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    task automatic do_write(input logic [7:0] addr, input logic [31:0] data, input logic [3:0] strb,
                            input logic [2:0] prot, input int aw_dly, input int w_dly,
                            input logic [1:0] exp_resp, input string req);
        bit aw_done = 0, w_done = 0, hs_aw, hs_w;
        int t = 0;
        while (!(aw_done && w_done) && t < 50) begin
            awvalid = !aw_done && (t >= aw_dly);
            awaddr = addr; awprot = prot;
            wvalid = !w_done && (t >= w_dly);
            wdata = data; wstrb = strb;
            #1;
            hs_aw = awvalid && awready;
            hs_w = wvalid && wready;
            @(negedge clk);
            t++;
            if (hs_aw) aw_done = 1;
            if (hs_w) w_done = 1;
            awvalid = 1'b0; wvalid = 1'b0;
            if (aw_done != w_done) chk("R2", "no response on half write", {31'b0, bvalid}, 32'd0);
        end
        #1;
        chk("R2", "response after both halves", {31'b0, bvalid}, 32'd1);
        chk(req, "bresp", {30'b0, bresp}, {30'b0, exp_resp});
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); #1;
            chk("R5", "bvalid held", {31'b0, bvalid}, 32'd1);
            chk("R5", "bresp held", {30'b0, bresp}, {30'b0, exp_resp});
            chk("R5", "ready low while pending", {30'b0, awready, wready}, 32'd0);
        end
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        #1;
        chk("R5", "bvalid drops after accept", {31'b0, bvalid}, 32'd0);
        if (exp_resp == 2'b00) model[addr[3:2]] = merge(model[addr[3:2]], data, strb);
    endtask

    task automatic do_read(input logic [7:0] addr, input logic [2:0] prot,
                           input logic [31:0] exp_data, input logic [1:0] exp_resp, input string req);
        int t = 0;
        arvalid = 1'b1; araddr = addr; arprot = prot;
        #1;
        while (!arready && t < 50) begin @(negedge clk); #1; t++; end
        @(negedge clk);
        arvalid = 1'b0;
        #1;
        chk("R6", "rvalid after address", {31'b0, rvalid}, 32'd1);
        chk(req, "rdata", rdata, exp_data);
        chk(req, "rresp", {30'b0, rresp}, {30'b0, exp_resp});
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); #1;
            chk("R6", "rvalid held", {31'b0, rvalid}, 32'd1);
            chk("R6", "rdata held", rdata, exp_data);
            chk("R6", "arready low while pending", {31'b0, arready}, 32'd0);
        end
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
        #1;
        chk("R6", "rvalid drops after accept", {31'b0, rvalid}, 32'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "outputs low in reset", {27'b0, awready, wready, arready, bvalid, rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "readies high after reset", {29'b0, awready, wready, arready}, 32'd7);
        for (int i = 0; i < 4; i++) begin
            model[i] = '0;
            do_read(8'(i * 4), 3'b000, 32'd0, 2'b00, "R1");
        end
    endtask

    task automatic test_orders();
        do_write(8'h00, 32'hA1B2C3D4, 4'hF, 3'b000, 0, 0, 2'b00, "R8");
        do_write(8'h04, 32'h11223344, 4'hF, 3'b000, 0, 3, 2'b00, "R2");
        do_write(8'h08, 32'hCAFEF00D, 4'hF, 3'b000, 2, 0, 2'b00, "R2");
        for (int i = 0; i < 3; i++) do_read(8'(i * 4), 3'b000, model[i], 2'b00, "R8");
    endtask

    task automatic test_strobes();
        do_write(8'h04, 32'hEEDDCCBB, 4'b0101, 3'b000, 0, 0, 2'b00, "R3");
        do_read(8'h04, 3'b000, 32'h11DD33BB, 2'b00, "R3");
        do_write(8'h00, 32'h00FF0000, 4'b1000, 3'b000, 1, 0, 2'b00, "R3");
        do_read(8'h00, 3'b000, 32'h00B2C3D4, 2'b00, "R3");
    endtask

    task automatic test_zero_strobe();
        do_write(8'h08, 32'hFFFFFFFF, 4'b0000, 3'b000, 0, 0, 2'b00, "R4");
        do_read(8'h08, 3'b000, 32'hCAFEF00D, 2'b00, "R4");
    endtask

    task automatic test_addressing();
        do_write(8'hF1, 32'h5A5A0003, 4'hF, 3'b000, 0, 0, 2'b00, "R7");
        do_read(8'h03, 3'b000, 32'h5A5A0003, 2'b00, "R7");
        do_read(8'h0C, 3'b000, 32'h0, 2'b00, "R7");
        do_read(8'h20, 3'b000, model[0], 2'b00, "R7");
    endtask

    task automatic test_fetch_reject();
        do_write(8'h0C, 32'h12345678, 4'hF, 3'b100, 0, 0, 2'b10, "R9");
        do_read(8'h0C, 3'b000, 32'h0, 2'b00, "R9");
        do_read(8'h04, 3'b100, 32'h0, 2'b10, "R9");
        do_write(8'h0C, 32'h87654321, 4'hF, 3'b011, 1, 0, 2'b00, "R9");
        do_read(8'h0C, 3'b011, 32'h87654321, 2'b00, "R9");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_orders();
        test_strobes();
        test_zero_strobe();
        test_addressing();
        test_fetch_reject();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule